// File: doc/BRIEF.md
# Prefix-Tracking Sequence Monitor with Causality Flags

This block is a runtime checker that follows a fixed, cycle-by-cycle pattern of expected input conditions. The pattern has `NSTEPS` entries. Each entry is a conjunction over an `NBITS`-wide vector of event and guard bits. A guarded event is expressed by requiring both the guard bit and the event bit. Each clock, the monitor samples one valuation of the vector. It reports the length of the longest pattern prefix that matches the most recent inputs. When a cycle breaks the current match, the monitor falls back in the way a string-matching automaton does: it keeps the longest suffix of the trace that is still a prefix of the pattern.

A small set of scoreboard flags records causing events. An entry can raise flags when the monitor advances through it. An entry can also require flags before it is allowed to match. A move to a lower state withdraws the flags that were raised on the part of the path being abandoned. The pattern and the flag masks are fixed at elaboration through parameters.

Top module: `seq_prefix_monitor`

## Requirements
- R1: `state_o` always lies in 0..`NSTEPS`. It equals the length of the longest matched pattern prefix ending at the most recent sampled input.
- R2: Exactly one input vector is consumed per rising clock edge. The state rises by at most one per edge.
- R3: Entry j uses bits `[j*NBITS +: NBITS]` of `CARE_MASK` and `VALUE_MASK`. It matches an input when every bit set in its care field equals the corresponding value bit. Bits outside the care field have no effect.
- R4: From state s, the next state is the largest k ≤ min(`NSTEPS`, s+1) such that entries 0..k-1 matched the last k inputs in order, each judged with the flags present in its own cycle. This includes staying at the same state.
- R5: Entering state k ≥ 1 raises the flags in field `[(k-1)*NFLAGS +: NFLAGS]` of `SET_MASK`.
- R6: Entry j additionally matches only if every flag in field `[j*NFLAGS +: NFLAGS]` of `CHK_MASK` is set in that cycle.
- R7: A move from state s to a lower state k first clears the `SET_MASK` flags of entries k..s-1, then applies R5. At state 0 no flag is set.
- R8: `match_o` is high exactly in the cycles where the state is `NSTEPS`. The following step starts from the fallback of the full pattern, so overlapping occurrences are each reported.
- R9: A synchronous active-high `rst` drives the state to 0, `match_o` low and all flags clear on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | NBITS | Event and guard valuation for this cycle |
| state_o | output | clog2(NSTEPS+1) | Length of the longest matched prefix |
| match_o | output | 1 | High while the whole pattern is matched |

## Verification
The bench builds the block with 4 input bits, 4 steps and 2 flags. Bit0 is event A, bit1 is event B and bit2 is guard G. Entry 0 needs A and raises flag0. Entry 1 is all don't-care and raises flag1. Entry 2 needs A and G, requires flag0 and raises flag0 again. Entry 3 needs B and requires flag1. Because flag0 is shared between entries 0 and 2, a fallback from state 3 to state 2 empties flag0, and the next occurrence of A with G is then refused. That makes the clearing and gating rules visible at `state_o`. The don't-care entry makes self-loops, guard misses and back-to-back overlapping matches reachable with short traces. A random trace is compared cycle by cycle against a suffix-matching reference that keeps its own history of inputs and flags.

// File: rtl/seqmon_pkg.sv
`timescale 1ns/1ps
package seqmon_pkg;

   // Width needed to hold a state index 0..steps.
   function automatic int unsigned state_bits(input int unsigned steps);
      return (steps < 1) ? 1 : $clog2(steps + 1);
   endfunction

   // Kind of move the tracker takes on one edge.
   typedef enum logic [1:0] {
      MV_IDLE = 2'd0,
      MV_FWD  = 2'd1,
      MV_HOLD = 2'd2,
      MV_BACK = 2'd3
   } move_e;

endpackage

// File: rtl/seqmon_entry_match.sv
`timescale 1ns/1ps
module seqmon_entry_match #(
   parameter int                NBITS  = 4,
   parameter int                NFLAGS = 2,
   parameter bit                USE_SB = 1'b1,
   parameter logic [NBITS-1:0]  CARE   = '0,
   parameter logic [NBITS-1:0]  VAL    = '0,
   parameter logic [NFLAGS-1:0] NEED   = '0
) (
   input  logic [NBITS-1:0]  ev_i,
   input  logic [NFLAGS-1:0] flags_i,
   output logic              hit_o
);

   logic bits_ok;

   // Only cared-about bits take part in the comparison.
   assign bits_ok = (((ev_i ^ VAL) & CARE) == '0);

   generate
      if (USE_SB) begin : g_gated
         assign hit_o = bits_ok && ((flags_i & NEED) == NEED);
      end else begin : g_free
         assign hit_o = bits_ok;
      end
   endgenerate

endmodule

// File: rtl/seqmon_prefix_track.sv
`timescale 1ns/1ps
module seqmon_prefix_track #(
   parameter int NSTEPS = 4,
   parameter int SW     = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NSTEPS-1:0] hit_i,
   output logic [SW-1:0]     state_o,
   output logic [SW-1:0]     nxt_o
);

   // live_q[j]: prefix of length j matches the trace ending last cycle.
   // The full-length bit never feeds a longer prefix, so it is not kept.
   logic [NSTEPS-1:1] live_q;
   logic [NSTEPS:1]   live_d;

   generate
      for (genvar j = 1; j <= NSTEPS; j++) begin : g_col
         if (j == 1) begin : g_head
            assign live_d[j] = hit_i[0];
         end else begin : g_tail
            assign live_d[j] = live_q[j-1] & hit_i[j-1];
         end
      end
   endgenerate

   // Longest surviving prefix is the next state.
   always_comb begin
      nxt_o = '0;
      for (int j = 1; j <= NSTEPS; j++) begin
         if (live_d[j]) nxt_o = SW'(j);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         live_q  <= '0;
         state_o <= '0;
      end else begin
         live_q  <= live_d[NSTEPS-1:1];
         state_o <= nxt_o;
      end
   end

endmodule

// File: rtl/seqmon_scoreboard.sv
`timescale 1ns/1ps
module seqmon_scoreboard
   import seqmon_pkg::*;
#(
   parameter int                       NSTEPS   = 4,
   parameter int                       NFLAGS   = 2,
   parameter int                       SW       = 3,
   parameter bit                       USE_SB   = 1'b1,
   parameter logic [NSTEPS*NFLAGS-1:0] SET_MASK = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  move_e             mv_i,
   input  logic [SW-1:0]     cur_i,
   input  logic [SW-1:0]     nxt_i,
   output logic [NFLAGS-1:0] flags_o
);

   generate
      if (USE_SB) begin : g_board
         logic [NFLAGS-1:0] clr, add, flags_d;

         always_comb begin
            clr = '0;
            add = '0;
            for (int j = 0; j < NSTEPS; j++) begin
               // Entries on the abandoned stretch of a backward move.
               if (mv_i == MV_BACK && SW'(j) >= nxt_i && SW'(j) < cur_i)
                  clr = clr | SET_MASK[j*NFLAGS +: NFLAGS];
               // Entry just consumed to land in the new state.
               if (SW'(j + 1) == nxt_i)
                  add = add | SET_MASK[j*NFLAGS +: NFLAGS];
            end
            flags_d = (flags_o & ~clr) | add;
         end

         always_ff @(posedge clk) begin
            if (rst) flags_o <= '0;
            else     flags_o <= flags_d;
         end
      end else begin : g_none
         assign flags_o = '0;
      end
   endgenerate

endmodule

// File: rtl/seq_prefix_monitor.sv
`timescale 1ns/1ps
module seq_prefix_monitor
   import seqmon_pkg::*;
#(
   parameter int                       NBITS      = 4,
   parameter int                       NSTEPS     = 4,
   parameter int                       NFLAGS     = 2,
   parameter bit                       USE_SB     = 1'b1,
   parameter logic [NSTEPS*NBITS-1:0]  CARE_MASK  = 16'h2501,
   parameter logic [NSTEPS*NBITS-1:0]  VALUE_MASK = 16'h2501,
   parameter logic [NSTEPS*NFLAGS-1:0] CHK_MASK   = 8'h90,
   parameter logic [NSTEPS*NFLAGS-1:0] SET_MASK   = 8'h19,
   localparam int                      SW         = state_bits(NSTEPS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NBITS-1:0] ev_i,
   output logic [SW-1:0]    state_o,
   output logic             match_o
);

   // Elaboration-time parameter checks.
   generate
      if (NSTEPS < 2) begin : g_bad_steps
         $error("seq_prefix_monitor: NSTEPS must be at least 2");
      end
      if (NBITS < 1) begin : g_bad_bits
         $error("seq_prefix_monitor: NBITS must be at least 1");
      end
      if (NFLAGS < 1) begin : g_bad_flags
         $error("seq_prefix_monitor: NFLAGS must be at least 1");
      end
      if ((VALUE_MASK & ~CARE_MASK) != '0) begin : g_bad_value
         $error("seq_prefix_monitor: value bits set outside care field");
      end
   endgenerate

   logic [NFLAGS-1:0] sb_flags;
   logic [NSTEPS-1:0] hits;
   logic [SW-1:0]     nxt_state;
   move_e             mv;

   generate
      for (genvar j = 0; j < NSTEPS; j++) begin : g_entry
         seqmon_entry_match #(
            .NBITS  (NBITS),
            .NFLAGS (NFLAGS),
            .USE_SB (USE_SB),
            .CARE   (CARE_MASK[j*NBITS +: NBITS]),
            .VAL    (VALUE_MASK[j*NBITS +: NBITS]),
            .NEED   (CHK_MASK[j*NFLAGS +: NFLAGS])
         ) u_entry (
            .ev_i    (ev_i),
            .flags_i (sb_flags),
            .hit_o   (hits[j])
         );
      end
   endgenerate

   seqmon_prefix_track #(
      .NSTEPS (NSTEPS),
      .SW     (SW)
   ) u_track (
      .clk     (clk),
      .rst     (rst),
      .hit_i   (hits),
      .state_o (state_o),
      .nxt_o   (nxt_state)
   );

   always_comb begin
      if (nxt_state > state_o)       mv = MV_FWD;
      else if (nxt_state < state_o)  mv = MV_BACK;
      else if (state_o == '0)        mv = MV_IDLE;
      else                           mv = MV_HOLD;
   end

   seqmon_scoreboard #(
      .NSTEPS   (NSTEPS),
      .NFLAGS   (NFLAGS),
      .SW       (SW),
      .USE_SB   (USE_SB),
      .SET_MASK (SET_MASK)
   ) u_board (
      .clk     (clk),
      .rst     (rst),
      .mv_i    (mv),
      .cur_i   (state_o),
      .nxt_i   (nxt_state),
      .flags_o (sb_flags)
   );

   assign match_o = (state_o == SW'(NSTEPS));

endmodule

// File: rtl/seqmon_chk.sv
`timescale 1ns/1ps
module seqmon_chk #(
   parameter int                       NSTEPS   = 4,
   parameter int                       NFLAGS   = 2,
   parameter int                       SW       = 3,
   parameter logic [NSTEPS*NFLAGS-1:0] SET_MASK = '0
) (
   input logic              clk,
   input logic              rst,
   input logic [SW-1:0]     state,
   input logic              match,
   input logic [NFLAGS-1:0] flags
);

   logic [NFLAGS-1:0] last_set;

   always_comb begin
      last_set = '0;
      for (int j = 0; j < NSTEPS; j++)
         if (SW'(j + 1) == state) last_set = SET_MASK[j*NFLAGS +: NFLAGS];
   end

   a_r1_state_in_range: assert property (@(posedge clk) disable iff (rst)
      int'(state) <= NSTEPS);

   a_r2_rise_by_one: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> int'(state) <= int'($past(state)) + 1);

   a_r8_match_from_top: assert property (@(posedge clk) disable iff (rst)
      (match && !$past(rst)) |-> int'($past(state)) >= NSTEPS - 1);

   a_r9_reset_clears: assert property (@(posedge clk)
      rst |=> (state == '0 && !match && flags == '0));

   a_r7_empty_at_zero: assert property (@(posedge clk) disable iff (rst)
      (state == '0) |-> (flags == '0));

   a_r5_entry_flags_held: assert property (@(posedge clk) disable iff (rst)
      (state != '0) |-> ((flags & last_set) == last_set));

endmodule

bind seq_prefix_monitor seqmon_chk #(
   .NSTEPS   (NSTEPS),
   .NFLAGS   (NFLAGS),
   .SW       (SW),
   .SET_MASK (USE_SB ? SET_MASK : '0)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .state (state_o),
   .match (match_o),
   .flags (sb_flags)
);

// File: tb/sim_seq_prefix_monitor.sv
`timescale 1ns/1ps
module sim_seq_prefix_monitor;

   localparam int NB = 4;
   localparam int NS = 4;
   localparam int NF = 2;
   localparam int SW = 3;
   localparam logic [NS*NB-1:0] CARE = 16'h2501;
   localparam logic [NS*NB-1:0] VALS = 16'h2501;
   localparam logic [NS*NF-1:0] CHK  = 8'h90;
   localparam logic [NS*NF-1:0] SETM = 8'h19;

   localparam logic [NB-1:0] X0  = 4'b0000;
   localparam logic [NB-1:0] XA  = 4'b0001;
   localparam logic [NB-1:0] XB  = 4'b0010;
   localparam logic [NB-1:0] XAG = 4'b0101;
   localparam logic [NB-1:0] XABG = 4'b0111;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NB-1:0] ev = '0;
   logic [SW-1:0] st;
   logic mt;

   always #10 clk = ~clk;

   seq_prefix_monitor #(
      .NBITS (NB), .NSTEPS (NS), .NFLAGS (NF), .USE_SB (1'b1),
      .CARE_MASK (CARE), .VALUE_MASK (VALS), .CHK_MASK (CHK), .SET_MASK (SETM)
   ) u0 (
      .clk (clk), .rst (rst), .ev_i (ev), .state_o (st), .match_o (mt)
   );

   int checks = 0;
   int fails  = 0;

   // Reference model: history of inputs and of the flags seen with them.
   logic [NB-1:0] hx [NS];
   logic [NF-1:0] hf [NS];
   int            ms;
   logic [NF-1:0] mf;

   function automatic bit ent_ok(input int j, input logic [NB-1:0] x,
                                 input logic [NF-1:0] f);
      logic [NB-1:0] c, v;
      logic [NF-1:0] n;
      c = CARE[j*NB +: NB];
      v = VALS[j*NB +: NB];
      n = CHK[j*NF +: NF];
      return ((x & c) == (v & c)) && ((f & n) == n);
   endfunction

   task automatic model_clear();
      for (int i = 0; i < NS; i++) begin
         hx[i] = '0;
         hf[i] = '0;
      end
      ms = 0;
      mf = '0;
   endtask

   task automatic model_step(input logic [NB-1:0] x);
      int lim, k;
      logic [NF-1:0] clr;
      for (int i = NS - 1; i > 0; i--) begin
         hx[i] = hx[i-1];
         hf[i] = hf[i-1];
      end
      hx[0] = x;
      hf[0] = mf;
      lim = (ms + 1 > NS) ? NS : ms + 1;
      k = 0;
      for (int c = lim; c >= 1; c--) begin
         bit ok;
         ok = 1'b1;
         for (int i = 0; i < c; i++)
            if (!ent_ok(i, hx[c-1-i], hf[c-1-i])) ok = 1'b0;
         if (ok) begin
            k = c;
            break;
         end
      end
      clr = '0;
      for (int j = 0; j < NS; j++)
         if (j >= k && j < ms) clr = clr | SETM[j*NF +: NF];
      mf = mf & ~clr;
      if (k > 0) mf = mf | SETM[(k-1)*NF +: NF];
      ms = k;
   endtask

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // Drive one vector at a falling edge, compare after the next rising edge.
   task automatic step(input logic [NB-1:0] x, input string tag);
      ev = x;
      model_step(x);
      @(posedge clk);
      @(negedge clk);
      check({tag, " R4 state vs reference"}, int'(st), ms);
      check({tag, " R8 match vs reference"}, int'(mt), (ms == NS) ? 1 : 0);
   endtask

   task automatic step_exp(input logic [NB-1:0] x, input int exp_state,
                           input string tag);
      step(x, tag);
      check({tag, " directed state"}, int'(st), exp_state);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      ev  = '0;
      @(posedge clk);
      @(negedge clk);
      check("R9 state after reset", int'(st), 0);
      check("R9 match after reset", int'(mt), 0);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_clear();
   endtask

   task automatic t_straight();
      do_reset();
      step_exp(XA,  1, "R1 straight e0");
      step_exp(X0,  2, "R3 straight e1 dont-care");
      step_exp(XAG, 3, "R5 straight e2 flag0 present");
      step_exp(XB,  4, "R8 straight full");
      check("R8 match high at full", int'(mt), 1);
      step_exp(X0,  0, "R8 one-cycle pulse");
      check("R8 match drops", int'(mt), 0);
   endtask

   task automatic t_guard();
      do_reset();
      step_exp(XA, 1, "R3 guard e0");
      step_exp(X0, 2, "R3 guard e1");
      step_exp(XA, 1, "R3 guard missing refuses e2");
      step_exp(XB, 2, "R4 guard fallback resumes");
   endtask

   task automatic t_fallback();
      do_reset();
      step_exp(XA,  1, "R4 hold e0");
      step_exp(XA,  2, "R4 hold e1");
      step_exp(XA,  2, "R4 self-loop at 2");
      step_exp(XAG, 3, "R4 advance to 3");
      step_exp(XAG, 3, "R4 self-loop at 3");
   endtask

   task automatic t_causality();
      do_reset();
      step_exp(XA,  1, "R6 cause e0");
      step_exp(XA,  2, "R6 cause e1");
      step_exp(XAG, 3, "R6 check passes");
      step_exp(X0,  2, "R7 back to 2 clears flag0");
      step_exp(XAG, 1, "R6 check refuses without flag0");
   endtask

   task automatic t_overlap();
      do_reset();
      step_exp(XA,   1, "R8 ovl e0");
      step_exp(X0,   2, "R8 ovl e1");
      step_exp(XAG,  3, "R8 ovl e2");
      step_exp(XABG, 4, "R8 ovl first full");
      step_exp(XAG,  3, "R8 fallback from full");
      step_exp(XB,   4, "R8 second full");
      check("R8 overlap match", int'(mt), 1);
   endtask

   task automatic t_reset_mid();
      do_reset();
      step_exp(XA,  1, "R9 pre e0");
      step_exp(X0,  2, "R9 pre e1");
      step_exp(XAG, 3, "R9 pre e2");
      do_reset();
      step_exp(XB,  0, "R9 no leftover progress");
   endtask

   task automatic t_random();
      int prev;
      do_reset();
      prev = 0;
      for (int n = 0; n < 3000; n++) begin
         logic [NB-1:0] x;
         x    = NB'($urandom);
         x[0] = (($urandom % 4) != 0);
         step(x, "R1 random");
         check("R1 random range", (int'(st) <= NS) ? 1 : 0, 1);
         check("R2 random rise by one", (int'(st) <= prev + 1) ? 1 : 0, 1);
         prev = int'(st);
      end
   endtask

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      t_straight();
      t_guard();
      t_fallback();
      t_causality();
      t_overlap();
      t_reset_mid();
      t_random();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule